// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

This block is a small datapath. Four general registers (GA to GD), an address register AR and a data register DR all hang off one internal word-wide bus. In any cycle at most one source drives the bus. A 2-bit source select passes through a decoder that is gated by a drive enable, and that decoder picks one of the four general registers. When the register path is not enabled, an external word can drive the bus instead. When nothing drives it, the bus is reported as undriven: `bus_valid` is low and the data reads as zero. The block uses no tri-state logic.

A destination load vector latches the bus into one register on the next rising clock edge. The same bus also feeds a small word-addressed memory, which is always addressed by AR. A memory write stores the bus word at `mem[AR]`. A memory read copies `mem[AR]` into DR. The memory operation of each cycle is decoded into one of three named operations: IDLE (neither strobe), READ (`mem_rd` alone) and WRITE (`mem_wr`, with or without `mem_rd`). There is no multi-cycle sequencer. Every transfer completes in the cycle it is requested. Memory contents are undefined until written.

Top module: `bus_xfer_unit`

## Requirements
- R1: A synchronous active-high `rst` clears GA, GD, GB, GC, DR and AR to zero on the rising edge.
- R2: With `src_en`=1, `bus_valid` is 1 in the same cycle and `bus_data` equals the register that `src_sel` picks: 00 selects GA, 01 GB, 10 GC and 11 GD. This holds even if `ext_drive` is also 1.
- R3: With `src_en`=0 and `ext_drive`=1, the bus carries `ext_data` with `bus_valid`=1. With both at 0, `bus_valid` is 0 and `bus_data` is all zeros.
- R4: `dst_load` bit 0 loads GA, bit 1 GB, bit 2 GC, bit 3 GD and bit 5 DR from the bus on the next rising edge. Registers that are not loaded keep their values.
- R5: When several `dst_load` bits are set, only the lowest-indexed one takes effect.
- R6: While `bus_valid` is 0, `dst_load` is ignored and no register changes. The one exception is a memory read into DR.
- R7: A memory read (`mem_rd`=1, `mem_wr`=0) loads DR with `mem[AR]` on the next edge. It takes precedence over a bus load of DR in the same cycle.
- R8: A memory write (`mem_wr`=1) with `bus_valid`=1 stores `bus_data` at `mem[AR]` on the edge. With `bus_valid`=0 the write is dropped and the memory word keeps its value.
- R9: When `mem_rd` and `mem_wr` are both 1, the write proceeds and the read is ignored, so DR is not loaded from memory.
- R10: `dst_load` bit 4 loads AR from the low AW bits of the bus on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | General register picked to drive the bus |
| src_en | input | 1 | Enables the register source decoder |
| ext_drive | input | 1 | External word drives the bus when `src_en` is 0 |
| ext_data | input | DW | External word |
| dst_load | input | 6 | Destination load request, bit 0 GA to bit 5 DR |
| mem_rd | input | 1 | Memory read into DR |
| mem_wr | input | 1 | Memory write from the bus |
| bus_data | output | DW | Bus word, zero when undriven |
| bus_valid | output | 1 | High when some source drives the bus |
| a_q | output | DW | Register GA |
| b_q | output | DW | Register GB |
| c_q | output | DW | Register GC |
| d_q | output | DW | Register GD |
| ar_q | output | AW | Address register |
| dr_q | output | DW | Data register |

## Verification
The bus outputs are combinational, so they are due in the same cycle as the stimulus. The scoreboard compares them 1 ns after inputs change on the falling edge, before the next rising edge. Register, AR and DR results are due one rising edge later, and the scoreboard tags each one with the following cycle's number. A memory write is observed only through a later read into DR, so its effect shows up two edges after the write is requested.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

    localparam int NUM_SRC = 4;
    localparam int DST_AR  = 4;
    localparam int DST_DR  = 5;
    localparam int NUM_DST = 6;

    typedef enum logic [1:0] {
        MEM_IDLE,
        MEM_READ,
        MEM_WRITE
    } mem_op_e;

endpackage

// File: rtl/bxu_bus.sv
module bxu_bus #(
    parameter int DW   = 8,
    parameter int NSRC = 4,
    parameter int SW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0][DW-1:0] src_word,
    input  logic [SW-1:0]           sel,
    input  logic                    src_en,
    input  logic                    ext_drive,
    input  logic [DW-1:0]           ext_word,
    output logic [DW-1:0]           bus_word,
    output logic                    bus_ok
);

    // Decoder: one-hot grant, all zero when the register path is disabled.
    logic [NSRC-1:0] grant;
    always_comb begin
        grant = '0;
        if (src_en) begin
            grant[sel] = 1'b1;
        end
    end

    // One AND-OR selector per bus bit across the matching bit of each source.
    logic [DW-1:0] reg_word;
    generate
        for (genvar b = 0; b < DW; b++) begin : g_bit
            logic [NSRC-1:0] column;
            for (genvar i = 0; i < NSRC; i++) begin : g_src
                assign column[i] = src_word[i][b];
            end
            assign reg_word[b] = |(column & grant);
        end
    endgenerate

    assign bus_word = src_en ? reg_word : (ext_drive ? ext_word : '0);
    assign bus_ok   = src_en | ext_drive;

endmodule

// File: rtl/bxu_dst_pick.sv
module bxu_dst_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // Isolate the lowest set request bit.
    assign grant = req & (~req + N'(1));

endmodule

// File: rtl/bxu_mem.sv
module bxu_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

    assign rdata = store[addr];

endmodule

// File: rtl/bus_xfer_unit.sv
module bus_xfer_unit
    import bxu_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(NUM_SRC)-1:0] src_sel,
    input  logic                       src_en,
    input  logic                       ext_drive,
    input  logic [DW-1:0]              ext_data,
    input  logic [NUM_DST-1:0]         dst_load,
    input  logic                       mem_rd,
    input  logic                       mem_wr,
    output logic [DW-1:0]              bus_data,
    output logic                       bus_valid,
    output logic [DW-1:0]              a_q,
    output logic [DW-1:0]              b_q,
    output logic [DW-1:0]              c_q,
    output logic [DW-1:0]              d_q,
    output logic [AW-1:0]              ar_q,
    output logic [DW-1:0]              dr_q
);

    logic [NUM_SRC-1:0][DW-1:0] gp_q;
    logic [AW-1:0]              ar_r;
    logic [DW-1:0]              dr_r;
    logic [DW-1:0]              mem_rdata;
    logic [NUM_DST-1:0]         ld_grant;
    logic                       mem_we;
    logic                       rd_take;
    mem_op_e                    op;

    bxu_bus #(.DW(DW), .NSRC(NUM_SRC)) u_bus (
        .src_word  (gp_q),
        .sel       (src_sel),
        .src_en    (src_en),
        .ext_drive (ext_drive),
        .ext_word  (ext_data),
        .bus_word  (bus_data),
        .bus_ok    (bus_valid)
    );

    bxu_dst_pick #(.N(NUM_DST)) u_pick (
        .req   (dst_load & {NUM_DST{bus_valid}}),
        .grant (ld_grant)
    );

    // Memory operation of this cycle; write wins over a simultaneous read.
    always_comb begin
        unique case ({mem_wr, mem_rd})
            2'b01:        op = MEM_READ;
            2'b10, 2'b11: op = MEM_WRITE;
            default:      op = MEM_IDLE;
        endcase
    end

    assign mem_we  = (op == MEM_WRITE) && bus_valid;
    assign rd_take = (op == MEM_READ);

    bxu_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ar_r),
        .wdata (bus_data),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gp_q <= '0;
            ar_r <= '0;
            dr_r <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (ld_grant[i]) begin
                    gp_q[i] <= bus_data;
                end
            end
            if (ld_grant[DST_AR]) begin
                ar_r <= bus_data[AW-1:0];
            end
            if (rd_take) begin
                dr_r <= mem_rdata;
            end else if (ld_grant[DST_DR]) begin
                dr_r <= bus_data;
            end
        end
    end

    assign a_q  = gp_q[0];
    assign b_q  = gp_q[1];
    assign c_q  = gp_q[2];
    assign d_q  = gp_q[3];
    assign ar_q = ar_r;
    assign dr_q = dr_r;

endmodule

// File: rtl/bxu_checker.sv
module bxu_checker #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    src_sel,
    input logic          src_en,
    input logic          ext_drive,
    input logic [5:0]    dst_load,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] bus_data,
    input logic          bus_valid,
    input logic [DW-1:0] a_q,
    input logic [DW-1:0] b_q,
    input logic [DW-1:0] c_q,
    input logic [DW-1:0] d_q,
    input logic [AW-1:0] ar_q,
    input logic [DW-1:0] dr_q
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (a_q == '0 && b_q == '0 && c_q == '0 && d_q == '0 && ar_q == '0 && dr_q == '0));

    a_r2_select_a: assert property (@(posedge clk) disable iff (rst)
        (src_en && src_sel == 2'b00) |-> (bus_valid && bus_data == a_q));

    a_r3_undriven_zero: assert property (@(posedge clk) disable iff (rst)
        (!src_en && !ext_drive) |-> (!bus_valid && bus_data == '0));

    a_r5_lowest_only: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && dst_load[0]) |=> ($stable(b_q) && $stable(c_q) && $stable(d_q) && $stable(ar_q)));

    a_r6_no_bus_hold: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid && !(mem_rd && !mem_wr)) |=>
        ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(d_q) && $stable(ar_q) && $stable(dr_q)));

    a_r9_read_dropped: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_wr && !(bus_valid && dst_load == 6'b100000)) |=> $stable(dr_q));

endmodule

bind bus_xfer_unit bxu_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .src_en    (src_en),
    .ext_drive (ext_drive),
    .dst_load  (dst_load),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .bus_data  (bus_data),
    .bus_valid (bus_valid),
    .a_q       (a_q),
    .b_q       (b_q),
    .c_q       (c_q),
    .d_q       (d_q),
    .ar_q      (ar_q),
    .dr_q      (dr_q)
);

// File: tb/sim_bus_xfer_unit.sv
`timescale 1ns/1ps
module sim_bus_xfer_unit;

    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    src_sel;
    logic          src_en;
    logic          ext_drive;
    logic [DW-1:0] ext_data;
    logic [5:0]    dst_load;
    logic          mem_rd;
    logic          mem_wr;
    logic [DW-1:0] bus_data;
    logic          bus_valid;
    logic [DW-1:0] a_q, b_q, c_q, d_q, dr_q;
    logic [AW-1:0] ar_q;

    always #2.5 clk = ~clk;

    bus_xfer_unit #(.DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .src_sel(src_sel), .src_en(src_en),
        .ext_drive(ext_drive), .ext_data(ext_data), .dst_load(dst_load),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_data(bus_data),
        .bus_valid(bus_valid), .a_q(a_q), .b_q(b_q), .c_q(c_q), .d_q(d_q),
        .ar_q(ar_q), .dr_q(dr_q)
    );

    typedef struct {
        int               due;
        bit               is_bus;
        logic [7:0]       e_bus;
        logic             e_ok;
        logic [5:0][7:0]  e_r;
        string            req;
    } item_t;

    item_t           sbq[$];
    int              ncyc = 0;
    int              nchk = 0;
    int              nerr = 0;
    bit              done = 1'b0;
    logic [5:0][7:0] mr;
    logic [7:0]      mm [16];

    always @(posedge clk) ncyc <= ncyc + 1;

    // Monitor: compares each due item 1 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].due == ncyc) begin
                item_t it;
                logic [5:0][7:0] got;
                it = sbq.pop_front();
                nchk++;
                if (it.is_bus) begin
                    if (bus_data !== it.e_bus || bus_valid !== it.e_ok) begin
                        nerr++;
                        $display("FAIL %s bus: got data=%h valid=%b expected data=%h valid=%b",
                                 it.req, bus_data, bus_valid, it.e_bus, it.e_ok);
                    end
                end else begin
                    got = {dr_q, {4'h0, ar_q}, d_q, c_q, b_q, a_q};
                    if (got !== it.e_r) begin
                        nerr++;
                        $display("FAIL %s regs: got %h expected %h", it.req, got, it.e_r);
                    end
                end
            end
        end
    end

    // Driver: applies one cycle of stimulus, updates the model, queues expectations.
    task automatic step(input logic [1:0] s, input logic en, input logic ex,
                        input logic [7:0] xd, input logic [5:0] ld,
                        input logic rd, input logic wr, input string req);
        item_t bi, ri;
        logic [7:0] bv;
        logic ok;
        logic [5:0][7:0] nx;
        int win;
        @(negedge clk);
        src_sel = s; src_en = en; ext_drive = ex; ext_data = xd;
        dst_load = ld; mem_rd = rd; mem_wr = wr;
        ok = en | ex;
        bv = en ? mr[s] : (ex ? xd : 8'h00);
        nx = mr;
        win = -1;
        if (ok) begin
            for (int i = 5; i >= 0; i--) if (ld[i]) win = i;
        end
        if (win >= 0 && win < 4) nx[win] = bv;
        if (win == 4) nx[4] = {4'h0, bv[3:0]};
        if (rd && !wr) nx[5] = mm[mr[4][3:0]];
        else if (win == 5) nx[5] = bv;
        if (wr && ok) mm[mr[4][3:0]] = bv;
        bi.due = ncyc; bi.is_bus = 1'b1; bi.e_bus = bv; bi.e_ok = ok; bi.e_r = '0; bi.req = req;
        ri.due = ncyc + 1; ri.is_bus = 1'b0; ri.e_bus = '0; ri.e_ok = 1'b0; ri.e_r = nx; ri.req = req;
        sbq.push_back(bi);
        sbq.push_back(ri);
        mr = nx;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got no completion expected completion");
            report();
        end
    end

    initial begin
        mr = '0;
        for (int i = 0; i < 16; i++) mm[i] = 8'h00;
        rst = 1'b1; src_sel = 2'b00; src_en = 1'b0; ext_drive = 1'b0;
        ext_data = '0; dst_load = '0; mem_rd = 1'b0; mem_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values, R3 idle bus
        step(2'd0, 0, 0, 8'h00, 6'b000000, 0, 0, "R1");
        // R4 load each general register from the external word
        step(2'd0, 0, 1, 8'h3C, 6'b000001, 0, 0, "R4");
        step(2'd0, 0, 1, 8'hA5, 6'b000010, 0, 0, "R4");
        step(2'd0, 0, 1, 8'h7E, 6'b000100, 0, 0, "R4");
        step(2'd0, 0, 1, 8'h81, 6'b001000, 0, 0, "R4");
        step(2'd0, 0, 1, 8'h9B, 6'b010000, 0, 0, "R10");
        step(2'd0, 0, 1, 8'h55, 6'b100000, 0, 0, "R4");
        // R2 source select, each code
        for (int s = 0; s < 4; s++) step(2'(s), 1, 0, 8'h00, 6'b000000, 0, 0, "R2");
        step(2'd1, 1, 1, 8'hFF, 6'b000000, 0, 0, "R2");
        // R4 register to register move, GA to GD
        step(2'd0, 1, 0, 8'h00, 6'b001000, 0, 0, "R4");
        // R5 two loads: only GB takes GC
        step(2'd2, 1, 0, 8'h00, 6'b001010, 0, 0, "R5");
        // R6 loads ignored while undriven
        step(2'd0, 0, 0, 8'h00, 6'b111111, 0, 0, "R6");
        step(2'd3, 0, 0, 8'hC3, 6'b000000, 0, 0, "R3");
        // R8 memory writes at AR=B
        step(2'd0, 1, 0, 8'h00, 6'b000000, 0, 1, "R8");
        step(2'd0, 0, 0, 8'h00, 6'b000000, 0, 1, "R8");
        step(2'd0, 0, 1, 8'h02, 6'b010000, 0, 0, "R10");
        step(2'd2, 1, 0, 8'h00, 6'b000000, 0, 1, "R8");
        // R7 read back
        step(2'd0, 0, 0, 8'h00, 6'b000000, 1, 0, "R7");
        step(2'd0, 0, 1, 8'h0B, 6'b010000, 0, 0, "R10");
        step(2'd0, 0, 1, 8'h11, 6'b100000, 1, 0, "R7");
        // R9 simultaneous read and write
        step(2'd1, 1, 0, 8'h00, 6'b000000, 1, 1, "R9");
        step(2'd0, 0, 0, 8'h00, 6'b000000, 1, 0, "R9");
        // R5 AR below DR
        step(2'd0, 0, 1, 8'hE7, 6'b110000, 0, 0, "R5");
        step(2'd0, 0, 0, 8'h00, 6'b000000, 0, 0, "R3");
        while (sbq.size() > 0) @(negedge clk);
        #2;
        done = 1'b1;
        report();
    end

endmodule